// File: doc/BRIEF.md
# Serially Programmed PRG Bank Mapper

This block is a cartridge-side memory mapper for an 8-bit CPU bus. Software programs it one bit per write. Each CPU write into the upper 32 KB address window delivers bit 0 of the data byte into a 5-bit shift register. The fifth such write moves the assembled value into an internal register. Address bits 14:13 of that fifth write choose the destination register. A write with data bit 7 set discards any partial sequence and forces the fixed-last-bank layout.

Two registers live here: a control register and a PRG bank register. The control register holds the mirroring select, the PRG banking mode and the CHR mode bit. The PRG bank register holds the switchable 16 KB bank number. For every CPU address in the upper window, the block combinationally produces a physical PRG ROM address. It also drives the two-bit mirroring select for the video memory. The number of 16 KB banks is a parameter, and the highest-numbered bank is treated as the last bank.

Top module: `serial_bank_mapper`

## Requirements
- R1: After rst_ni is released, the mapper is in fixed-last mode (mode 3) with mirror_o = 00, chr_mode_o = 0 and bank register 0. CPU addresses $8000-$BFFF map to bank 0 and $C000-$FFFF map to bank NUM_BANKS-1.
- R2: A write to $8000-$FFFF with data bit 7 set discards any partially shifted bits and sets the PRG mode field to 3. The mirroring and CHR-mode fields keep their values.
- R3: Writes with data bit 7 clear deliver data bit 0, least significant bit first. The fifth write loads the 5-bit value {b4..b0} into the control register when its address bits 14:13 are 00. Field positions are: bit 4 CHR mode, bits 3:2 PRG mode, bits 1:0 mirroring.
- R4: When address bits 14:13 of the fifth write are 11, the 5-bit value goes to the PRG bank register. Only its low clog2(NUM_BANKS) bits are kept.
- R5: When address bits 14:13 of the fifth write are 01 or 10, neither the control register nor the bank register changes.
- R6: Writes with address bit 15 clear have no effect on the registers or on the partial shift sequence.
- R7: mirror_o carries the control mirroring field (00 single-screen low, 01 single-screen high, 10 vertical, 11 horizontal). chr_mode_o carries control bit 4.
- R8: In mode 3, prg_addr_o = {bank, A[13:0]} for A[14]=0 and {NUM_BANKS-1, A[13:0]} for A[14]=1.
- R9: In mode 2, prg_addr_o = {0, A[13:0]} for A[14]=0 and {bank, A[13:0]} for A[14]=1.
- R10: In modes 0 and 1, prg_addr_o = {bank with bit 0 replaced by A[14], A[13:0]}, which selects a 32 KB bank and ignores bank bit 0.
- R11: After a fifth write commits a value, the next five writes assemble a new value independent of earlier bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_i | input | 16 | CPU address, used for writes and read mapping |
| cpu_data_i | input | 8 | CPU write data |
| prg_addr_o | output | clog2(NUM_BANKS)+14 | Physical PRG ROM address for cpu_addr_i |
| mirror_o | output | 2 | Mirroring select |
| chr_mode_o | output | 1 | CHR bank mode bit |

## Verification
The bench builds the block with the default of eight banks, so bank numbers are 3 bits wide and the last bank is 7. This lets a written 5-bit value such as 0x1D show its upper bits being dropped (it lands as bank 5). The 32 KB modes map bank 5 and bank 4 to the same pair, which shows that bank bit 0 is ignored. With eight banks, mode 3 (last bank 7) and mode 2 (first bank 0) give different fixed windows, so each mode's fixed half is told apart from its switchable half.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'b00,
    SEL_CHR_A = 2'b01,
    SEL_CHR_B = 2'b10,
    SEL_PRG   = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic       chr_mode;
    logic [1:0] prg_mode;
    logic [1:0] mirror;
  } ctrl_t;

  localparam int unsigned SHIFT_W = 5;
  localparam ctrl_t CTRL_RESET = '{chr_mode: 1'b0, prg_mode: 2'd3, mirror: 2'd0};
endpackage

// File: rtl/serial_loader.sv
module serial_loader
  import mapper_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         data_i,
  input  logic [1:0]         sel_i,
  output logic               clr_o,
  output logic               commit_o,
  output logic [SHIFT_W-1:0] value_o,
  output reg_sel_e           sel_o
);
  localparam int unsigned CNT_W = $clog2(SHIFT_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SHIFT_W - 1);

  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;

  assign clr_o    = wr_i & data_i[7];
  assign commit_o = wr_i & ~data_i[7] & (cnt_q == LAST_CNT);
  assign value_o  = {data_i[0], shift_q[SHIFT_W-1:1]};
  assign sel_o    = reg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (clr_o || commit_o) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (wr_i) begin
      shift_q <= {data_i[0], shift_q[SHIFT_W-1:1]};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> (cnt_q == '0) && (shift_q == '0));
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (cnt_q == '0));
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int unsigned BANK_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               commit_i,
  input  reg_sel_e           sel_i,
  input  logic [SHIFT_W-1:0] value_i,
  output ctrl_t              ctrl_o,
  output logic [BANK_W-1:0]  bank_o
);
  ctrl_t             ctrl_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
      bank_q <= '0;
    end else if (clr_i) begin
      ctrl_q.prg_mode <= 2'd3;
    end else if (commit_i) begin
      case (sel_i)
        SEL_CTRL: ctrl_q <= ctrl_t'(value_i);
        SEL_PRG:  bank_q <= value_i[BANK_W-1:0];
        default:  ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign bank_o = bank_q;

  p_mode_force_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ctrl_q.prg_mode == 2'd3) && $stable(ctrl_q.mirror) && $stable(ctrl_q.chr_mode));
  p_chr_sel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && (sel_i == SEL_CHR_A || sel_i == SEL_CHR_B)) |=> $stable(ctrl_q) && $stable(bank_q));
  p_ctrl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && sel_i == SEL_CTRL) |=> (ctrl_q == ctrl_t'($past(value_i))));
endmodule

// File: rtl/prg_map.sv
module prg_map
  import mapper_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [14:0]       addr_i,
  input  ctrl_t             ctrl_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [BANK_W+13:0] prg_addr_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] bank32;
  logic [BANK_W-1:0] sel_bank;

  generate
    if (BANK_W > 1) begin : g_wide
      assign bank32 = {bank_i[BANK_W-1:1], addr_i[14]};
    end else begin : g_narrow
      assign bank32 = addr_i[14];
    end
  endgenerate

  always_comb begin
    case (ctrl_i.prg_mode)
      2'd2:    sel_bank = addr_i[14] ? bank_i : '0;
      2'd3:    sel_bank = addr_i[14] ? LAST_BANK : bank_i;
      default: sel_bank = bank32;
    endcase
  end

  assign prg_addr_o = {sel_bank, addr_i[13:0]};

  p_fixed_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.prg_mode == 2'd3 && addr_i[14]) |-> (prg_addr_o[BANK_W+13:14] == LAST_BANK));
  p_fixed_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.prg_mode == 2'd2 && !addr_i[14]) |-> (prg_addr_o[BANK_W+13:14] == '0));
  p_offset_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_addr_o[13:0] == addr_i[13:0]);
endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS),
  parameter int unsigned PRG_AW    = BANK_W + 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic [1:0]        mirror_o,
  output logic              chr_mode_o
);
  logic               wr_hi;
  logic               clr;
  logic               commit;
  logic [SHIFT_W-1:0] value;
  reg_sel_e           sel;
  ctrl_t              ctrl;
  logic [BANK_W-1:0]  bank;

  assign wr_hi = cpu_wr_i & cpu_addr_i[15];

  serial_loader u_loader (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_hi),
    .data_i   (cpu_data_i),
    .sel_i    (cpu_addr_i[14:13]),
    .clr_o    (clr),
    .commit_o (commit),
    .value_o  (value),
    .sel_o    (sel)
  );

  mapper_regs #(.BANK_W(BANK_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .commit_i (commit),
    .sel_i    (sel),
    .value_i  (value),
    .ctrl_o   (ctrl),
    .bank_o   (bank)
  );

  prg_map #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (cpu_addr_i[14:0]),
    .ctrl_i     (ctrl),
    .bank_i     (bank),
    .prg_addr_o (prg_addr_o)
  );

  assign mirror_o   = ctrl.mirror;
  assign chr_mode_o = ctrl.chr_mode;

  p_low_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_addr_i[15]) |=> $stable(mirror_o) && $stable(chr_mode_o));
endmodule

// File: tb/serial_bank_mapper_tb.sv
module serial_bank_mapper_tb;
  localparam int PRG_AW = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [15:0]       addr = '0;
  logic [7:0]        data = '0;
  logic [PRG_AW-1:0] prg_addr;
  logic [1:0]        mirror;
  logic              chr_mode;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  serial_bank_mapper u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cpu_wr_i   (wr),
    .cpu_addr_i (addr),
    .cpu_data_i (data),
    .prg_addr_o (prg_addr),
    .mirror_o   (mirror),
    .chr_mode_o (chr_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ser_write(input logic [15:0] a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) cpu_write(a, {7'd0, v[i]});
  endtask

  task automatic read_check(input string req, input logic [15:0] a, input logic [2:0] bank);
    @(negedge clk);
    addr = a;
    #1;
    check(req, prg_addr, {bank, a[13:0]});
  endtask

  task automatic t_reset;
    read_check("R1 low window bank0", 16'h8000, 3'd0);
    read_check("R1 high window last bank", 16'hFFFC, 3'd7);
    check("R1 mirror", mirror, 2'd0);
    check("R1 chr mode", chr_mode, 1'b0);
  endtask

  task automatic t_ctrl;
    ser_write(16'h8000, 5'h1E);
    #1;
    check("R3 R7 mirror vertical", mirror, 2'd2);
    check("R3 R7 chr mode", chr_mode, 1'b1);
    ser_write(16'h9FFF, 5'h0F);
    #1;
    check("R3 R7 mirror horizontal", mirror, 2'd3);
    check("R3 chr mode cleared", chr_mode, 1'b0);
  endtask

  task automatic t_bank;
    ser_write(16'hE000, 5'h1D);
    read_check("R4 R8 masked bank at low window", 16'hA001, 3'd5);
    read_check("R8 fixed last", 16'hC000, 3'd7);
  endtask

  task automatic t_mode2;
    ser_write(16'h8000, 5'h0B);
    read_check("R9 first bank fixed", 16'h8010, 3'd0);
    read_check("R9 switch high", 16'hD000, 3'd5);
  endtask

  task automatic t_mode32;
    ser_write(16'h8000, 5'h01);
    read_check("R10 mode0 low half", 16'h8000, 3'd4);
    read_check("R10 mode0 high half", 16'hC004, 3'd5);
    check("R7 single-screen high", mirror, 2'd1);
    ser_write(16'h8000, 5'h05);
    ser_write(16'hE000, 5'h04);
    read_check("R10 mode1 bit0 ignored low", 16'h8000, 3'd4);
    read_check("R10 mode1 bit0 ignored high", 16'hFFFF, 3'd5);
  endtask

  task automatic t_reset_write;
    cpu_write(16'hA000, 8'h80);
    read_check("R2 mode forced to 3", 16'hC000, 3'd7);
    check("R2 mirror kept", mirror, 2'd1);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'hFFFF, 8'hFF);
    ser_write(16'hE000, 5'h02);
    read_check("R2 partial bits discarded", 16'h8000, 3'd2);
    check("R2 mirror unchanged by partial", mirror, 2'd1);
  endtask

  task automatic t_chr_regions;
    ser_write(16'hA000, 5'h1F);
    ser_write(16'hC000, 5'h00);
    #1;
    check("R5 control untouched", mirror, 2'd1);
    read_check("R5 bank untouched", 16'h8000, 3'd2);
    ser_write(16'hE000, 5'h06);
    read_check("R11 fresh sequence after commit", 16'h8000, 3'd6);
  endtask

  task automatic t_low_addr;
    for (int i = 0; i < 5; i++) cpu_write(16'h6000, 8'h01);
    cpu_write(16'h7FFF, 8'h80);
    #1;
    check("R6 mirror untouched", mirror, 2'd1);
    read_check("R6 bank untouched", 16'h8000, 3'd6);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h6000, 8'h81);
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h0000, 8'h01);
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hE000, 8'h00);
    read_check("R6 R3 sequence spans low writes", 16'h8000, 3'd3);
    check("R3 fifth address picks bank reg", mirror, 2'd1);
  endtask

  initial begin
    #(8 * 100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_bank();
    t_mode2();
    t_mode32();
    t_reset_write();
    t_chr_regions();
    t_low_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule